// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master with Register Port

This block is a serial peripheral master that moves one byte per transfer. It is driven through a small 32-bit register port. Software first selects a slave through one-hot enables in the control word and chooses clock polarity, clock phase and a divider in the configuration word. A write to the transmit register then starts a transfer. The block shifts the byte out MSB first while it shifts the slave's answer in. When the last bit is done, the received byte sits in the receive register.

Software learns that a transfer has finished in two ways. It can poll a done bit in the control word. It can also use an interrupt status register whose bits are cleared by writing ones and which drives an interrupt line through a mask. The serial clock is the functional clock divided by a 5-bit prescaler. Software chooses the divisor by rounding up, so the serial rate never exceeds what was requested. The configuration word also holds fields for lane count, phase lane usage, queue mode and word length. These fields are kept and read back, but shifting always uses a single data line.

Top module: `spi_byte_master`

## Requirements
- R1: Control register at offset 0x00 holds chip-select enables in bits 19:16, one bit per slave. A set bit drives that slave's select output active (low by default), and writing zero there releases every select. Bit 0 reads as the done flag.
- R2: Configuration register at offset 0x04: bit 7 is clock polarity and bit 6 is clock phase, so modes 0 to 3 are {pol,pha} = 00, 01, 10, 11. While no transfer runs, the serial clock rests at the polarity level.
- R3: A write to the transmit register at offset 0x08 starts one 8-bit transfer, MSB first. With phase 0 the input is sampled on the leading clock edge and the output changes on the trailing edge; with phase 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R4: Configuration bits 4:0 hold the prescaler p, where a value of 0 acts as 1. Each serial clock half-period lasts ceil(p/2) functional clock cycles. A transfer lasts 16 half-periods, counted from the write cycle to the cycle in which the done flag reads 1.
- R5: The done flag (control bit 0) reads 0 in the cycle after a transfer starts and reads 1 once the last edge has occurred.
- R6: Interrupt status register at offset 0x28: bit 0 is transfer-done and bit 1 is ready. Both bits are set when a transfer completes. Writing a 1 to a bit clears that bit, and writing a 0 leaves it unchanged.
- R7: The interrupt output is the OR of the status bits gated by the mask register at offset 0x2C, which uses the same bit positions. A mask of all zeros keeps the output low.
- R8: A write to the transmit register while a transfer is running is ignored. The running byte, its length and the received byte are not affected.
- R9: Configuration bit 9 is a flush request. It reads 1 in the cycle right after it is written and clears itself one cycle later.
- R10: Writing 1 to configuration bit 16 is a soft reset. It aborts any transfer, so the clock returns to the polarity level, and it clears the done flag and the receive register. The status register becomes 2'b10 (ready only). Bit 16 always reads 0.
- R11: Configuration bits 11:10 (lane count), 13 and 12 (instruction and address lane usage), 17 (queue mode) and 5 (word length) are stored and read back. Shifting stays single-lane whatever their values.
- R12: The receive register at offset 0x0C returns the received byte in bits 7:0, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Masked interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_o | output | CS_N | Slave selects, active low by default |

## Verification
A wrong edge counter or wrong divider state shows up as a done flag that rises too early or too late. The bench counts the exact cycle of that rise for several prescaler values. A sampling or shifting state that is off by one edge corrupts the byte. This is seen on the serial output pins within the same transfer and in the receive register as soon as the done flag rises, for all four modes. A status register with stale or sticky bits shows at the interrupt pin in the first cycle after the mask or the status changes, and leftover state from an aborted transfer shows on the serial clock pin in the cycle after the soft reset.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
   // register offsets (the map is decoded by software, so it is fixed)
   localparam logic [7:0] OFS_CTL  = 8'h00;
   localparam logic [7:0] OFS_CFG  = 8'h04;
   localparam logic [7:0] OFS_TXD  = 8'h08;
   localparam logic [7:0] OFS_RXD  = 8'h0C;
   localparam logic [7:0] OFS_IST  = 8'h28;
   localparam logic [7:0] OFS_IMSK = 8'h2C;

   // field positions
   localparam int B_DONE  = 0;
   localparam int B_CSLO  = 16;
   localparam int PSC_W   = 5;
   localparam int B_BLEN  = 5;
   localparam int B_CPHA  = 6;
   localparam int B_CPOL  = 7;
   localparam int B_FLUSH = 9;
   localparam int B_LANE  = 10;
   localparam int B_ADRL  = 12;
   localparam int B_INSL  = 13;
   localparam int B_SRST  = 16;
   localparam int B_QUEUE = 17;
   localparam int IST_W   = 2;

   typedef struct packed {
      logic             queue;
      logic             ins_lane;
      logic             adr_lane;
      logic [1:0]       lanes;
      logic             cpol;
      logic             cpha;
      logic             blen;
      logic [PSC_W-1:0] psc;
   } cfg_t;
endpackage

// File: rtl/spibm_clkdiv.sv
module spibm_clkdiv #(
   parameter int PSC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   localparam int SUM_W = PSC_W + 1;

   logic [SUM_W-1:0] psc_p1;
   logic [PSC_W-1:0] half_m1;
   logic [PSC_W-1:0] half_q;
   logic [PSC_W-1:0] cnt_q;

   // half period = ceil(p/2), p = 0 acts as 1
   always_comb begin
      psc_p1 = {1'b0, psc} + SUM_W'(1);
      if (psc == '0) half_m1 = '0;
      else           half_m1 = PSC_W'((psc_p1 >> 1) - SUM_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
         half_q <= half_m1;
      end else if (run) begin
         cnt_q <= (cnt_q == half_q) ? '0 : cnt_q + PSC_W'(1);
      end
   end

   assign tick = run && !clear && (cnt_q == half_q);
endmodule

// File: rtl/spibm_engine.sv
module spibm_engine #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              tick,
   input  logic              cpol_cfg,
   input  logic              cpha_cfg,
   input  logic [BYTE_W-1:0] tx_in,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              fin,
   output logic [BYTE_W-1:0] rx_out
);
   localparam int EDGES = 2 * BYTE_W;
   localparam int EW    = $clog2(EDGES);

   logic [EW-1:0]     edge_q;
   logic              ph_q, cpol_q, cpha_q, busy_q;
   logic [BYTE_W-1:0] txs_q, rxs_q;
   logic              odd, last, smp, shf, step;

   always_comb begin
      odd  = edge_q[0];
      last = (edge_q == EW'(EDGES - 1));
      step = busy_q && tick;
      // phase 0: sample leading, shift trailing; phase 1: the reverse
      smp  = cpha_q ? odd : !odd;
      shf  = cpha_q ? (!odd && (edge_q != '0)) : (odd && !last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         edge_q <= '0;
         ph_q   <= 1'b0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         txs_q  <= '0;
         rxs_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         edge_q <= '0;
         ph_q   <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         edge_q <= '0;
         ph_q   <= 1'b0;
         cpol_q <= cpol_cfg;
         cpha_q <= cpha_cfg;
         txs_q  <= tx_in;
         rxs_q  <= '0;
      end else if (step) begin
         ph_q   <= ~ph_q;
         edge_q <= edge_q + EW'(1);
         if (smp) rxs_q <= {rxs_q[BYTE_W-2:0], miso};
         if (shf) txs_q <= {txs_q[BYTE_W-2:0], 1'b0};
         if (last) busy_q <= 1'b0;
      end
   end

   assign fin    = step && last && !abort;
   assign rx_out = smp ? {rxs_q[BYTE_W-2:0], miso} : rxs_q;
   assign sclk   = busy_q ? (cpol_q ^ ph_q) : cpol_cfg;
   assign mosi   = txs_q[BYTE_W-1];
   assign busy   = busy_q;
endmodule

// File: rtl/spibm_regs.sv
module spibm_regs
   import spibm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CS_N   = 4,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              fin,
   input  logic [BYTE_W-1:0] rx_in,
   output logic              start,
   output logic              srst,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [CS_N-1:0]   cs_en,
   output logic              cpol,
   output logic              cpha,
   output logic [PSC_W-1:0]  psc,
   output logic              irq,
   output logic              done_o,
   output logic [IST_W-1:0]  ist_o,
   output logic              flush_o
);
   logic sel_ctl, sel_cfg, sel_txd, sel_ist, sel_imsk;

   cfg_t              cfg_q;
   logic [CS_N-1:0]   cs_q;
   logic [IST_W-1:0]  ist_q, imsk_q, w1c;
   logic              done_q, flush_q;
   logic [BYTE_W-1:0] rxd_q;
   logic              unused_wbits;

   assign sel_ctl  = reg_wen && (reg_addr == ADDR_W'(OFS_CTL));
   assign sel_cfg  = reg_wen && (reg_addr == ADDR_W'(OFS_CFG));
   assign sel_txd  = reg_wen && (reg_addr == ADDR_W'(OFS_TXD));
   assign sel_ist  = reg_wen && (reg_addr == ADDR_W'(OFS_IST));
   assign sel_imsk = reg_wen && (reg_addr == ADDR_W'(OFS_IMSK));

   assign srst    = sel_cfg && reg_wdata[B_SRST];
   assign start   = sel_txd && !busy;
   assign tx_byte = reg_wdata[BYTE_W-1:0];
   assign w1c     = sel_ist ? reg_wdata[IST_W-1:0] : '0;
   assign unused_wbits = ^{reg_wdata[31:18], reg_wdata[15:14], reg_wdata[8]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cs_q    <= '0;
         imsk_q  <= '0;
         ist_q   <= '0;
         done_q  <= 1'b0;
         flush_q <= 1'b0;
         rxd_q   <= '0;
      end else begin
         flush_q <= sel_cfg && reg_wdata[B_FLUSH];
         if (sel_ctl) cs_q <= reg_wdata[B_CSLO +: CS_N];
         if (sel_cfg) begin
            cfg_q.queue    <= reg_wdata[B_QUEUE];
            cfg_q.ins_lane <= reg_wdata[B_INSL];
            cfg_q.adr_lane <= reg_wdata[B_ADRL];
            cfg_q.lanes    <= reg_wdata[B_LANE +: 2];
            cfg_q.cpol     <= reg_wdata[B_CPOL];
            cfg_q.cpha     <= reg_wdata[B_CPHA];
            cfg_q.blen     <= reg_wdata[B_BLEN];
            cfg_q.psc      <= reg_wdata[PSC_W-1:0];
         end
         if (sel_imsk) imsk_q <= reg_wdata[IST_W-1:0];
         if (srst) begin
            ist_q  <= 2'b10;
            done_q <= 1'b0;
            rxd_q  <= '0;
         end else begin
            ist_q <= (ist_q & ~w1c) | {IST_W{fin}};
            if (start)    done_q <= 1'b0;
            else if (fin) done_q <= 1'b1;
            if (fin) rxd_q <= rx_in;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_CTL): begin
            reg_rdata[B_CSLO +: CS_N] = cs_q;
            reg_rdata[B_DONE]         = done_q;
         end
         ADDR_W'(OFS_CFG): begin
            reg_rdata[B_QUEUE]     = cfg_q.queue;
            reg_rdata[B_INSL]      = cfg_q.ins_lane;
            reg_rdata[B_ADRL]      = cfg_q.adr_lane;
            reg_rdata[B_LANE +: 2] = cfg_q.lanes;
            reg_rdata[B_FLUSH]     = flush_q;
            reg_rdata[B_CPOL]      = cfg_q.cpol;
            reg_rdata[B_CPHA]      = cfg_q.cpha;
            reg_rdata[B_BLEN]      = cfg_q.blen;
            reg_rdata[PSC_W-1:0]   = cfg_q.psc;
         end
         ADDR_W'(OFS_RXD):  reg_rdata[BYTE_W-1:0] = rxd_q;
         ADDR_W'(OFS_IST):  reg_rdata[IST_W-1:0]  = ist_q;
         ADDR_W'(OFS_IMSK): reg_rdata[IST_W-1:0]  = imsk_q;
         default:           reg_rdata = '0;
      endcase
   end

   assign cs_en   = cs_q;
   assign cpol    = cfg_q.cpol;
   assign cpha    = cfg_q.cpha;
   assign psc     = cfg_q.psc;
   assign irq     = |(ist_q & imsk_q);
   assign done_o  = done_q;
   assign ist_o   = ist_q;
   assign flush_o = flush_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spibm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CS_N       = 4,
   parameter int BYTE_W     = 8,
   parameter bit CS_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [CS_N-1:0]   spi_cs_o
);
   if (CS_N < 1 || CS_N > 4) begin : g_bad_cs
      $error("CS_N must be within 1..4");
   end
   if (BYTE_W < 2 || BYTE_W > 8) begin : g_bad_byte
      $error("BYTE_W must be within 2..8");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x2C");
   end

   logic              xfer_start, soft_rst, xfer_fin, div_tick, eng_busy;
   logic              cfg_cpol, cfg_cpha, done_flag, flush_flag;
   logic [PSC_W-1:0]  cfg_psc;
   logic [IST_W-1:0]  ist_bits;
   logic [BYTE_W-1:0] tx_byte, rx_byte;
   logic [CS_N-1:0]   cs_en;

   spibm_regs #(.ADDR_W(ADDR_W), .CS_N(CS_N), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(eng_busy),
      .fin(xfer_fin), .rx_in(rx_byte), .start(xfer_start), .srst(soft_rst),
      .tx_byte(tx_byte), .cs_en(cs_en), .cpol(cfg_cpol), .cpha(cfg_cpha),
      .psc(cfg_psc), .irq(irq), .done_o(done_flag), .ist_o(ist_bits),
      .flush_o(flush_flag)
   );

   spibm_clkdiv #(.PSC_W(PSC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start || soft_rst),
      .run(eng_busy), .psc(cfg_psc), .tick(div_tick)
   );

   spibm_engine #(.BYTE_W(BYTE_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(xfer_start), .abort(soft_rst),
      .tick(div_tick), .cpol_cfg(cfg_cpol), .cpha_cfg(cfg_cpha),
      .tx_in(tx_byte), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
      .busy(eng_busy), .fin(xfer_fin), .rx_out(rx_byte)
   );

   if (CS_ACT_LOW) begin : g_cs_low
      assign spi_cs_o = ~cs_en;
   end else begin : g_cs_high
      assign spi_cs_o = cs_en;
   end
endmodule

// File: rtl/spibm_chk.sv
module spibm_chk #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              busy,
   input logic              sclk,
   input logic              cpol,
   input logic              start,
   input logic              srst,
   input logic              fin,
   input logic              tick,
   input logic              done_flag,
   input logic [1:0]        ist,
   input logic              flush
);
   localparam int EDGES = 2 * BYTE_W;
   localparam int CW    = $clog2(EDGES) + 2;

   logic [CW-1:0] ticks_q;
   logic          flush_wr;

   assign flush_wr = reg_wen && (reg_addr == ADDR_W'(8'h04)) && reg_wdata[9];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ticks_q <= '0;
      else if (start)         ticks_q <= '0;
      else if (busy && tick)  ticks_q <= ticks_q + CW'(1);
   end

   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk == cpol);

   p_edge_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !$past(srst) |-> ticks_q == CW'(EDGES));

   p_start_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done_flag && busy);

   p_fin_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fin && !srst |=> done_flag && ist == 2'b11);

   p_flush_self_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush && !flush_wr |=> !flush);

   p_srst_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !busy && !done_flag && ist == 2'b10);
endmodule

bind spi_byte_master spibm_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .busy(eng_busy), .sclk(spi_sclk), .cpol(cfg_cpol),
   .start(xfer_start), .srst(soft_rst), .fin(xfer_fin), .tick(div_tick),
   .done_flag(done_flag), .ist(ist_bits), .flush(flush_flag)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
   localparam logic [7:0] A_CTL = 8'h00, A_CFG = 8'h04, A_TXD = 8'h08,
                          A_RXD = 8'h0C, A_IST = 8'h28, A_MSK = 8'h2C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [3:0]  spi_cs_o;

   int vectors = 0;
   int fails = 0;

   // slave model state
   logic       armed = 1'b0;
   logic       m_cpha = 1'b0;
   logic [7:0] sbyte = '0;
   logic [7:0] cap = '0;
   int         tgl = 0;

   always #5 clk = ~clk;

   spi_byte_master dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_o(spi_cs_o)
   );

   always @(spi_sclk) begin
      if (armed) begin
         int k;
         k = tgl;
         tgl = tgl + 1;
         if (!m_cpha) begin
            if (k % 2 == 0) cap = {cap[6:0], spi_mosi};
            else if (k < 15) spi_miso = sbyte[6 - k/2];
         end else begin
            if (k % 2 == 0) spi_miso = sbyte[7 - k/2];
            else cap = {cap[6:0], spi_mosi};
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic int half_of(input int p);
      return (p == 0) ? 1 : (p + 1) / 2;
   endfunction

   function automatic logic [31:0] cfg_word(input int mode, input int p);
      return (32'(mode / 2) << 7) | (32'(mode % 2) << 6) | 32'(p);
   endfunction

   // full transfer in the given mode, checking R2 R3 R4 R5 R12
   task automatic t_xfer(input int mode, input int p, input logic [31:0] extra,
                         input logic [7:0] tx, input logic [7:0] sb);
      logic [31:0] d;
      int c;
      wr(A_CFG, cfg_word(mode, p) | extra);
      m_cpha = mode[0];
      sbyte = sb;
      spi_miso = sb[7];
      tgl = 0; cap = '0; armed = 1'b1;
      wr(A_TXD, {24'h0, tx});
      c = 0;
      rd(A_CTL, d);
      chk("R5 done low after start", {31'h0, d[0]}, 32'h0);
      while (d[0] == 1'b0 && c < 5000) begin
         @(negedge clk);
         c++;
         rd(A_CTL, d);
      end
      armed = 1'b0;
      chk("R4 transfer length", c, 16 * half_of(p));
      chk("R5 done set at end", {31'h0, d[0]}, 32'h1);
      chk("R3 bits on mosi", {24'h0, cap}, {24'h0, tx});
      rd(A_RXD, d);
      chk("R12 received byte", d, {24'h0, sb});
      chk("R2 sclk rests at polarity", {31'h0, spi_sclk}, 32'(mode / 2));
      wr(A_IST, 32'h3);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_CTL, d);  chk("R1 reset control", d, 32'h0);
      chk("R1 selects idle", {28'h0, spi_cs_o}, 32'hF);
      chk("R2 sclk idle low", {31'h0, spi_sclk}, 32'h0);
      rd(A_IST, d);  chk("R6 reset status", d, 32'h0);
      chk("R7 irq low at reset", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_select;
      logic [31:0] d;
      wr(A_CTL, 32'h0004_0000);
      chk("R1 select slave 2", {28'h0, spi_cs_o}, 32'hB);
      rd(A_CTL, d); chk("R1 control readback", d, 32'h0004_0000);
      wr(A_CTL, 32'h0008_0000);
      chk("R1 select slave 3", {28'h0, spi_cs_o}, 32'h7);
      wr(A_CTL, 32'h0);
      chk("R1 all released", {28'h0, spi_cs_o}, 32'hF);
   endtask

   task automatic t_idle_pol;
      wr(A_CFG, cfg_word(2, 1));
      chk("R2 idle high with pol 1", {31'h0, spi_sclk}, 32'h1);
      wr(A_CFG, cfg_word(1, 1));
      chk("R2 idle low with pol 0", {31'h0, spi_sclk}, 32'h0);
   endtask

   task automatic t_status_irq;
      logic [31:0] d;
      wr(A_MSK, 32'h0);
      t_xfer_keep(0, 2, 8'h5A, 8'hC3);
      rd(A_IST, d); chk("R6 both status bits set", d, 32'h3);
      chk("R7 masked irq low", {31'h0, irq}, 32'h0);
      wr(A_MSK, 32'h2);
      chk("R7 irq with ready mask", {31'h0, irq}, 32'h1);
      wr(A_IST, 32'h2);
      rd(A_IST, d); chk("R6 clear ready only", d, 32'h1);
      chk("R7 irq drops when masked bit clear", {31'h0, irq}, 32'h0);
      wr(A_MSK, 32'h1);
      chk("R7 irq on done bit", {31'h0, irq}, 32'h1);
      wr(A_IST, 32'h0);
      rd(A_IST, d); chk("R6 zero write keeps bits", d, 32'h1);
      wr(A_IST, 32'h1);
      rd(A_IST, d); chk("R6 clear done", d, 32'h0);
      chk("R7 irq low after clear", {31'h0, irq}, 32'h0);
      wr(A_MSK, 32'h0);
   endtask

   // transfer that leaves the status register untouched
   task automatic t_xfer_keep(input int mode, input int p, input logic [7:0] tx,
                              input logic [7:0] sb);
      logic [31:0] d;
      int c;
      wr(A_CFG, cfg_word(mode, p));
      m_cpha = mode[0]; sbyte = sb; spi_miso = sb[7];
      tgl = 0; cap = '0; armed = 1'b1;
      wr(A_TXD, {24'h0, tx});
      c = 0;
      rd(A_CTL, d);
      while (d[0] == 1'b0 && c < 5000) begin
         @(negedge clk); c++; rd(A_CTL, d);
      end
      armed = 1'b0;
      chk("R3 mosi in status test", {24'h0, cap}, {24'h0, tx});
   endtask

   task automatic t_busy_write;
      logic [31:0] d;
      int c;
      wr(A_CFG, cfg_word(0, 6));
      m_cpha = 1'b0; sbyte = 8'h96; spi_miso = 1'b1;
      tgl = 0; cap = '0; armed = 1'b1;
      wr(A_TXD, 32'hA5);
      c = 0;
      repeat (5) begin @(negedge clk); c++; end
      wr(A_TXD, 32'h3C);
      c++;
      rd(A_CTL, d);
      while (d[0] == 1'b0 && c < 5000) begin
         @(negedge clk); c++; rd(A_CTL, d);
      end
      armed = 1'b0;
      chk("R8 length unchanged by busy write", c, 16 * half_of(6));
      chk("R8 running byte kept", {24'h0, cap}, 32'hA5);
      rd(A_RXD, d); chk("R8 received byte kept", d, 32'h96);
      repeat (4) @(negedge clk);
      chk("R8 no second transfer", {31'h0, spi_sclk}, 32'h0);
      rd(A_CTL, d); chk("R8 done stays set", {31'h0, d[0]}, 32'h1);
      wr(A_IST, 32'h3);
   endtask

   task automatic t_flush;
      logic [31:0] d;
      wr(A_CFG, cfg_word(1, 3) | 32'h200);
      rd(A_CFG, d); chk("R9 flush visible one cycle", {31'h0, d[9]}, 32'h1);
      @(negedge clk);
      rd(A_CFG, d); chk("R9 flush self cleared", d, cfg_word(1, 3));
   endtask

   task automatic t_fields;
      logic [31:0] d;
      logic [31:0] ext;
      ext = 32'h0002_3820;   // queue, ins/adr lanes, lanes=2, word length
      wr(A_CFG, ext | cfg_word(0, 3));
      rd(A_CFG, d); chk("R11 stored fields read back", d, ext | cfg_word(0, 3));
      t_xfer(0, 3, ext, 8'hE1, 8'h1E);
   endtask

   task automatic t_soft_reset;
      logic [31:0] d;
      wr(A_CFG, cfg_word(3, 4));
      m_cpha = 1'b1; sbyte = 8'hFF; spi_miso = 1'b1;
      tgl = 0; cap = '0; armed = 1'b1;
      wr(A_TXD, 32'h81);
      repeat (7) @(negedge clk);
      armed = 1'b0;
      wr(A_CFG, cfg_word(3, 4) | 32'h0001_0000);
      chk("R10 sclk back to polarity", {31'h0, spi_sclk}, 32'h1);
      rd(A_CTL, d); chk("R10 done cleared", {31'h0, d[0]}, 32'h0);
      rd(A_IST, d); chk("R10 status ready only", d, 32'h2);
      rd(A_RXD, d); chk("R10 receive cleared", d, 32'h0);
      rd(A_CFG, d); chk("R10 reset bit reads zero", d, cfg_word(3, 4));
      repeat (40) begin
         @(negedge clk);
         if (spi_sclk !== 1'b1) chk("R10 clock stays idle", {31'h0, spi_sclk}, 32'h1);
      end
      chk("R10 clock idle after wait", {31'h0, spi_sclk}, 32'h1);
      wr(A_IST, 32'h3);
      t_xfer(3, 4, 32'h0, 8'h6B, 8'hB6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_idle_pol();
      t_xfer(0, 2, 32'h0, 8'hA5, 8'h3C);   // R3 mode 0
      t_xfer(1, 0, 32'h0, 8'h0F, 8'hF0);   // R3 mode 1, R4 p=0
      t_xfer(2, 5, 32'h0, 8'h81, 8'h7E);   // R3 mode 2, R4 odd p
      t_xfer(3, 1, 32'h0, 8'hC9, 8'h93);   // R3 mode 3, R4 p=1
      t_xfer(0, 31, 32'h0, 8'h01, 8'h80);  // R4 largest divider
      t_status_irq();
      t_busy_write();
      t_flush();
      t_fields();
      t_soft_reset();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule